// File: doc/BRIEF.md
# Trigger Mask Capture FIFO

This block records trigger decisions for later collection by software. Each time the capture strobe fires, the 128-bit trigger mask and its 16-bit transfer number go into one entry of a RAM-based FIFO. The FIFO has separate write and read address counters. Software reads the oldest entry through a small 16-bit register window: eight words for the mask and one word for the transfer number. The entry can be read as often as needed. Software moves to the next entry only by toggling a control bit.

The FIFO reports when it holds at least one unread entry. It also exposes both pointers and a sticky flag that records any dropped strobe. A global disable output rises while a fixed margin of slots is still free. Events already in flight after the disable can then still be stored. A second control bit, toggled the same way, clears both pointers and the overflow flag.

Top module: `trig_capture_fifo`

## Requirements
- R1: After reset the FIFO is empty, both pointers are 0, and `not_empty`, `global_disable` and `overflow_seen` are 0.
- R2: A strobe in a clock cycle where the FIFO is not full stores `cap_mask` and `cap_tnum` at the write pointer. The write pointer then increments by one at that clock edge.
- R3: Register address k (0 to 7) returns mask bits [16k+15:16k] of the head entry, and address 8 returns its transfer number. `reg_rdata` shows the word selected by `reg_addr` one clock after the address is applied.
- R4: The head entry reads the same on every read until the read pointer is advanced.
- R5: The control register sits at address 9 and reads back all 16 written bits. Bit 0 is the advance bit. A write that clears bit 0 while the stored bit 0 is 1 increments the read pointer at that edge. The increment is ignored when the FIFO is empty. A write of 0 over a stored 0 has no effect.
- R6: Bit 1 of the control register is the pointer reset. A write that clears bit 1 while the stored bit 1 is 1 sets both pointers to 0 and clears `overflow_seen`.
- R7: `not_empty` is 1 exactly when the write pointer differs from the read pointer, and the same value appears as bit 0 of the status register at address 10.
- R8: The write pointer and read pointer are driven on `wr_ptr` and `rd_ptr`. They are also readable, zero-extended, at addresses 11 and 12. Each pointer is 7 bits with the default depth of 64.
- R9: `global_disable` is 1 while the occupancy (write pointer minus read pointer) is at least 48. That is the depth of 64 minus a margin of 16. The same value appears as status bit 1.
- R10: A strobe while the FIFO holds 64 entries is dropped and the write pointer does not move. `overflow_seen` (status bit 2) is then set and stays set until a pointer reset.
- R11: Addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_strobe | input | 1 | Capture request for the current mask and number |
| cap_mask | input | 128 | Trigger mask to capture |
| cap_tnum | input | 16 | Transfer number to capture |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| not_empty | output | 1 | At least one unread entry |
| global_disable | output | 1 | Near-full request to stop triggers |
| overflow_seen | output | 1 | Sticky dropped-strobe flag |
| wr_ptr | output | 7 | Write pointer |
| rd_ptr | output | 7 | Read pointer |

## Verification
Strobes and control writes change the pointers, flags and disable at the clock edge where they are applied. The bench drives them on a falling edge and checks the status outputs at the next falling edge. Register reads have one cycle of latency. The read task queues the expected word when it applies an address, and the monitor pops the queue one falling edge after the registering edge. This keeps every comparison aligned with its own request. Fill-level checks sit just below and at the near-full threshold and at the full boundary, with one strobe beyond full.

// File: rtl/trig_capture_fifo.sv
module trig_capture_fifo #(
  parameter int MASK_W  = 128,
  parameter int TNUM_W  = 16,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int MARGIN  = 16,
  parameter int RADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_strobe,
  input  logic [MASK_W-1:0]    cap_mask,
  input  logic [TNUM_W-1:0]    cap_tnum,
  input  logic [RADDR_W-1:0]   reg_addr,
  input  logic                 reg_wr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 not_empty,
  output logic                 global_disable,
  output logic                 overflow_seen,
  output logic [ADDR_W:0]      wr_ptr,
  output logic [ADDR_W:0]      rd_ptr
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PW      = ADDR_W + 1;
  localparam int ENTRY_W = MASK_W + TNUM_W;
  localparam int NWORDS  = MASK_W / WORD_W;
  localparam int A_TNUM  = NWORDS;
  localparam int A_CTRL  = NWORDS + 1;
  localparam int A_STAT  = NWORDS + 2;
  localparam int A_WPTR  = NWORDS + 3;
  localparam int A_RPTR  = NWORDS + 4;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0]  ctrl_q;
  logic [WORD_W-1:0]  rd_next;
  logic [ENTRY_W-1:0] head;
  logic [PW-1:0]      occ;
  logic full, near_full, ctrl_wr, adv_fire, clr_fire, push, drop;

  assign occ       = wr_ptr - rd_ptr;
  assign full      = occ == PW'(DEPTH);
  assign not_empty = occ != '0;
  assign near_full = occ >= PW'(DEPTH - MARGIN);
  assign global_disable = near_full;

  assign ctrl_wr  = reg_wr && (reg_addr == RADDR_W'(A_CTRL));
  assign clr_fire = ctrl_wr && ctrl_q[1] && !reg_wdata[1];
  assign adv_fire = ctrl_wr && ctrl_q[0] && !reg_wdata[0] && !clr_fire;
  assign push     = cap_strobe && !full && !clr_fire;
  assign drop     = cap_strobe && full && !clr_fire;

  assign head = mem[rd_ptr[ADDR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[ADDR_W-1:0]] <= {cap_tnum, cap_mask};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr        <= '0;
      rd_ptr        <= '0;
      overflow_seen <= 1'b0;
      ctrl_q        <= '0;
      reg_rdata     <= '0;
    end else begin
      reg_rdata <= rd_next;
      if (ctrl_wr) ctrl_q <= reg_wdata;
      if (clr_fire) begin
        wr_ptr        <= '0;
        rd_ptr        <= '0;
        overflow_seen <= 1'b0;
      end else begin
        if (push) wr_ptr <= wr_ptr + 1'b1;
        if (adv_fire && not_empty) rd_ptr <= rd_ptr + 1'b1;
        if (drop) overflow_seen <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NWORDS; k++)
      if (reg_addr == RADDR_W'(k)) rd_next = head[k*WORD_W +: WORD_W];
    case (int'(reg_addr))
      A_TNUM:  rd_next = WORD_W'(head[MASK_W +: TNUM_W]);
      A_CTRL:  rd_next = ctrl_q;
      A_STAT:  rd_next = WORD_W'({overflow_seen, near_full, not_empty});
      A_WPTR:  rd_next = WORD_W'(wr_ptr);
      A_RPTR:  rd_next = WORD_W'(rd_ptr);
      default: ;
    endcase
  end

  assert_occ_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_seen && !clr_fire |=> overflow_seen);
  assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe && full && !clr_fire |=> $stable(wr_ptr));
  assert_ne_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_empty) |-> $past(cap_strobe));
  assert_gd_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(global_disable) |-> $past(cap_strobe));
  assert_adv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire && not_empty |=> rd_ptr == $past(rd_ptr) + 1'b1);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> wr_ptr == '0 && rd_ptr == '0 && !overflow_seen);
endmodule

// File: tb/trig_capture_fifo_tb.sv
module trig_capture_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_strobe = 1'b0;
  logic [127:0] cap_mask = '0;
  logic [15:0]  cap_tnum = '0;
  logic [3:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic         not_empty, global_disable, overflow_seen;
  logic [6:0]   wr_ptr, rd_ptr;

  trig_capture_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .cap_mask(cap_mask),
    .cap_tnum(cap_tnum), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .not_empty(not_empty),
    .global_disable(global_disable), .overflow_seen(overflow_seen),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int wr_m = 0, rd_m = 0, next_id = 0;
  bit ovf_m = 0;
  int slot_id [64];
  logic [15:0] ctrl_m = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0, req_d = 1'b0;

  function automatic logic [15:0] mword(int id, int k);
    return {id[7:0], k[3:0], 4'hC};
  endfunction
  function automatic logic [15:0] tnum(int id);
    return 16'hB000 + 16'(id);
  endfunction
  function automatic int occ_m();
    return (wr_m - rd_m + 128) % 128;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) req_d <= rd_req;
  always @(negedge clk) if (req_d) begin
    logic [15:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(32'(reg_rdata), 32'(e), t);
  end

  task automatic rd(logic [3:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    reg_addr = a;
    rd_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    if (a == 4'd9) begin
      if (ctrl_m[1] && !d[1]) begin wr_m = 0; rd_m = 0; ovf_m = 0; end
      else if (ctrl_m[0] && !d[0] && occ_m() != 0) rd_m = (rd_m + 1) % 128;
      ctrl_m = d;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    cap_strobe = 1'b1;
    for (int k = 0; k < 8; k++) cap_mask[k*16 +: 16] = mword(next_id, k);
    cap_tnum = tnum(next_id);
    if (occ_m() < 64) begin
      slot_id[wr_m % 64] = next_id;
      wr_m = (wr_m + 1) % 128;
    end else ovf_m = 1;
    next_id++;
    @(negedge clk);
    cap_strobe = 1'b0;
  endtask

  task automatic advance();
    wr(4'd9, ctrl_m | 16'h0001);
    wr(4'd9, ctrl_m & 16'hFFFE);
  endtask

  task automatic read_head(string tag);
    int id = slot_id[rd_m % 64];
    for (int k = 0; k < 8; k++) rd(4'(k), mword(id, k), tag);
    rd(4'd8, tnum(id), tag);
  endtask

  task automatic chk_status(string tag);
    chk(32'(not_empty), 32'(occ_m() != 0), {tag, " not_empty R7"});
    chk(32'(global_disable), 32'(occ_m() >= 48), {tag, " disable R9"});
    chk(32'(overflow_seen), 32'(ovf_m), {tag, " overflow R10"});
    chk(32'(wr_ptr), 32'(wr_m), {tag, " wr_ptr R8"});
    chk(32'(rd_ptr), 32'(rd_m), {tag, " rd_ptr R8"});
  endtask

  function automatic logic [15:0] stat_m();
    return {13'd0, ovf_m, occ_m() >= 48, occ_m() != 0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_status("R1 reset");
    rd(4'd10, 16'h0000, "R1 status after reset");

    for (int i = 0; i < 3; i++) strobe();
    chk_status("R2 three pushes");
    rd(4'd11, 16'd3, "R8 wptr register");
    rd(4'd12, 16'd0, "R8 rptr register");
    rd(4'd10, stat_m(), "R7 status nonempty");
    read_head("R3 head entry 0");
    read_head("R4 reread entry 0");

    advance();
    chk_status("R5 after advance");
    read_head("R3 head entry 1");
    advance();
    advance();
    chk_status("R5 drained");
    advance();
    chk_status("R5 advance on empty ignored");
    rd(4'd12, 16'(rd_m), "R5 rptr unchanged on empty");

    wr(4'd9, 16'hA5F0);
    chk_status("R5 zero over zero no effect");
    rd(4'd9, 16'hA5F0, "R5 control readback");
    rd(4'd13, 16'h0000, "R11 unused 13");
    rd(4'd15, 16'h0000, "R11 unused 15");

    for (int i = 0; i < 47; i++) strobe();
    chk_status("R9 occupancy 47");
    strobe();
    chk_status("R9 occupancy 48");
    rd(4'd10, stat_m(), "R9 status near full");
    for (int i = 0; i < 16; i++) strobe();
    chk_status("R10 full");
    strobe();
    chk_status("R10 strobe when full dropped");
    rd(4'd10, stat_m(), "R10 status overflow");
    read_head("R10 head intact after drop");

    advance();
    chk_status("R10 sticky after advance");
    strobe();
    chk_status("R2 push after room frees");
    read_head("R3 head after wrap");

    wr(4'd9, ctrl_m | 16'h0002);
    wr(4'd9, ctrl_m & 16'hFFFD);
    chk_status("R6 pointer reset");
    rd(4'd10, 16'h0000, "R6 status cleared");

    strobe();
    chk_status("R6 push after reset");
    read_head("R6 entry after reset");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 0, "scoreboard drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule